// File: doc/BRIEF.md
# Peripheral Clock Gating Controller

This block owns one 16-bit control register in which each implemented bit stops the clock of one on-chip peripheral. A further bit switches off the shared peripheral clock driver as a whole. Software reaches the register through a small single-cycle read/write port. A one-shot end-of-initialisation input locks the register. After that, only a key sequence written to a separate unlock address opens it again, and only for one access.

From the register the block derives registered clock enables for the external gating cells and a clock enable for the shared driver. It also derives a port-latch freeze flag, a gated clock output pin, and a qualifier per peripheral that says whether its registers may be accessed. When the CAN controller's disable bit is cleared, the block issues a reset pulse so that the controller restarts unconfigured. Interrupt requests pass through untouched in every mode.

Top module: `periph_clk_gate`

## Requirements
- R1: After reset the register reads 0x0000, every clock enable and access qualifier is 1, the driver clock enable is 1, and freeze and all reset pulses are 0.
- R2: Implemented disable bits are: bit 0 peripheral 0 (ADC), bit 1 peripheral 1 (async serial), bit 2 peripheral 2 (sync serial), bit 3 peripheral 3 (timers), bit 7 peripheral 4 (capture/compare A), bit 8 peripheral 5 (capture/compare B), bit 13 peripheral 6 (CAN), bit 15 driver disable. A read of the register address (0x0) returns the stored value with every other bit 0. A read of any other address returns 0.
- R3: `clk_en_o[i]` equals NOT(disable bit of i) AND NOT(bit 15). It changes only at the clock edge that accepts a register write, and so is first seen in the cycle after that write.
- R4: An accepted write that takes bit 13 from 1 to 0 drives `periph_rst_o[6]` high for exactly the two cycles after the write. No other peripheral ever gets a reset pulse.
- R5: Once `init_done_i` has been high at a clock edge, register writes are ignored unless unlocked. A write in the same cycle as `init_done_i` is still accepted.
- R6: The unlock sequence is a write of 0x00AA to address 0x1, then a write of 0x0055 to address 0x1 as the next access, then a register write as the next access. That write is accepted. Any other access in between aborts the sequence, and a new 0x00AA write restarts it. Cycles without an access leave the sequence as it is. The opening lasts for exactly one access.
- R7: While bit 15 is set, `pclk_en_o` is 0 and `clkout_o` is held at 1. Otherwise `pclk_en_o` is 1 and `clkout_o` follows `clkout_src_i`.
- R8: `port_freeze_o` equals bit 15 of the register.
- R9: While bit 15 is set, a generic peripheral (0 to 5) may be accessed only if its own disable bit is set. Outside that case generic peripherals are always accessible. The extended peripheral (6) may be accessed only when neither bit 15 nor its own disable bit is set.
- R10: `irq_o` equals `irq_i` in every register state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_req_i | input | 1 | Access strobe for the current cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Word address (0x0 register, 0x1 unlock) |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, combinational |
| init_done_i | input | 1 | End-of-initialisation pulse |
| clkout_src_i | input | 1 | Free-running clock to the output pin |
| irq_i | input | 8 | Interrupt requests from peripherals |
| clk_en_o | output | 7 | Per-peripheral clock enable |
| pclk_en_o | output | 1 | Shared peripheral clock driver enable |
| periph_rst_o | output | 7 | Per-peripheral reset pulse |
| reg_acc_ok_o | output | 7 | Per-peripheral register access allowed |
| port_freeze_o | output | 1 | Freeze port latch transfer and pin sampling |
| clkout_o | output | 1 | Gated clock output |
| irq_o | output | 8 | Interrupt requests, passed through |

## Verification
Two functions can fall into one cycle. The first pair is lock arrival and a register write. The bench raises `init_done_i` in the very cycle of a write and reads the value back to confirm the write went in. It then confirms that the next write is refused. The second pair is a CAN re-enable and a driver disable carried in a single unlocked write. Here the bench requires the two-cycle reset pulse to appear at the same time as freeze, the held clock output and all clock enables low. Before any of this, a sweep through every 16-bit value with the register unlocked compares all derived outputs against values computed from the bit map.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
  localparam int unsigned REG_W    = 16;
  localparam int unsigned N_PERIPH = 7;
  localparam int unsigned CAN_IDX  = 6;
  localparam int unsigned PCD_BIT  = 15;
  localparam int unsigned PERIPH_BIT [N_PERIPH] = '{0, 1, 2, 3, 7, 8, 13};
  // extended peripherals lose register access whenever they are gated
  localparam logic [N_PERIPH-1:0] EXT_MASK = 7'b100_0000;
  // peripherals that need a reset pulse on re-enable
  localparam logic [N_PERIPH-1:0] RST_MASK = 7'b100_0000;

  typedef enum logic [1:0] {UL_IDLE, UL_KEY1, UL_ARMED} unlock_state_e;

  function automatic logic [REG_W-1:0] impl_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < N_PERIPH; i++) m[PERIPH_BIT[i]] = 1'b1;
    m[PCD_BIT] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/pcg_unlock.sv
module pcg_unlock
  import pcg_pkg::*;
#(
  parameter logic [REG_W-1:0] KEY1 = 16'h00AA,
  parameter logic [REG_W-1:0] KEY2 = 16'h0055
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic             we_i,
  input  logic             hit_unl_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic             armed_o
);
  unlock_state_e state_q, state_d;
  logic key_wr;

  assign key_wr = acc_i & we_i & hit_unl_i;

  always_comb begin
    state_d = state_q;
    if (acc_i) begin
      if (key_wr && wdata_i == KEY1)
        state_d = UL_KEY1;
      else if (key_wr && wdata_i == KEY2 && state_q == UL_KEY1)
        state_d = UL_ARMED;
      else
        state_d = UL_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= UL_IDLE;
    else         state_q <= state_d;
  end

  assign armed_o = (state_q == UL_ARMED);
endmodule

// File: rtl/pcg_ctrl_reg.sv
module pcg_ctrl_reg
  import pcg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             init_done_i,
  input  logic             armed_i,
  output logic [REG_W-1:0] ctrl_q_o,
  output logic [REG_W-1:0] ctrl_d_o,
  output logic             lock_o
);
  localparam logic [REG_W-1:0] IMPL = impl_mask();

  logic [REG_W-1:0] ctrl_q;
  logic             lock_q;
  logic             wr_ok;

  assign wr_ok    = wr_en_i & (~lock_q | armed_i);
  assign ctrl_d_o = wr_ok ? (wdata_i & IMPL) : ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      lock_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d_o;
      if (init_done_i) lock_q <= 1'b1;
    end
  end

  assign ctrl_q_o = ctrl_q;
  assign lock_o   = lock_q;
endmodule

// File: rtl/pcg_rst_pulser.sv
module pcg_rst_pulser #(
  parameter int unsigned            N          = 7,
  parameter logic [N-1:0]           MASK       = '0,
  parameter int unsigned            RST_CYCLES = 2,
  localparam int unsigned           CNT_W      = $clog2(RST_CYCLES + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] rst_o
);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(RST_CYCLES);

  for (genvar i = 0; i < N; i++) begin : g_ch
    logic [CNT_W-1:0] cnt_q;
    logic             fire;
    assign fire = clr_i[i] & MASK[i];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             cnt_q <= '0;
      else if (fire)           cnt_q <= LOAD;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end
    assign rst_o[i] = (cnt_q != '0);
  end
endmodule

// File: rtl/pcg_gate_out.sv
module pcg_gate_out
  import pcg_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_PERIPH-1:0] dis_d_i,
  input  logic                pcd_d_i,
  input  logic [N_PERIPH-1:0] dis_q_i,
  input  logic                pcd_q_i,
  input  logic                clkout_src_i,
  output logic [N_PERIPH-1:0] clk_en_o,
  output logic                pclk_en_o,
  output logic                freeze_o,
  output logic                clkout_o,
  output logic [N_PERIPH-1:0] acc_ok_o
);
  // enables are flopped so the gating cells see a clean edge-aligned change
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_en_o  <= '1;
      pclk_en_o <= 1'b1;
    end else begin
      clk_en_o  <= ~dis_d_i & {N_PERIPH{~pcd_d_i}};
      pclk_en_o <= ~pcd_d_i;
    end
  end

  assign freeze_o = pcd_q_i;
  assign clkout_o = pcd_q_i | clkout_src_i;

  for (genvar i = 0; i < N_PERIPH; i++) begin : g_acc
    if (EXT_MASK[i]) begin : g_ext
      assign acc_ok_o[i] = ~pcd_q_i & ~dis_q_i[i];
    end else begin : g_gen
      assign acc_ok_o[i] = ~pcd_q_i | dis_q_i[i];
    end
  end
endmodule

// File: rtl/periph_clk_gate.sv
module periph_clk_gate
  import pcg_pkg::*;
#(
  parameter int unsigned      ADDR_W      = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR   = 4'h0,
  parameter logic [ADDR_W-1:0] UNL_ADDR   = 4'h1,
  parameter logic [REG_W-1:0] KEY1        = 16'h00AA,
  parameter logic [REG_W-1:0] KEY2        = 16'h0055,
  parameter int unsigned      RST_CYCLES  = 2,
  parameter int unsigned      IRQ_W       = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_req_i,
  input  logic                bus_we_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [REG_W-1:0]    bus_wdata_i,
  output logic [REG_W-1:0]    bus_rdata_o,
  input  logic                init_done_i,
  input  logic                clkout_src_i,
  input  logic [IRQ_W-1:0]    irq_i,
  output logic [N_PERIPH-1:0] clk_en_o,
  output logic                pclk_en_o,
  output logic [N_PERIPH-1:0] periph_rst_o,
  output logic [N_PERIPH-1:0] reg_acc_ok_o,
  output logic                port_freeze_o,
  output logic                clkout_o,
  output logic [IRQ_W-1:0]    irq_o
);
  logic             hit_reg, hit_unl, reg_wr, unl_armed, lock_q;
  logic [REG_W-1:0] ctrl_q, ctrl_d;
  logic [N_PERIPH-1:0] dis_q, dis_d, dis_clr;

  assign hit_reg = (bus_addr_i == REG_ADDR);
  assign hit_unl = (bus_addr_i == UNL_ADDR);
  assign reg_wr  = bus_req_i & bus_we_i & hit_reg;

  pcg_unlock #(.KEY1(KEY1), .KEY2(KEY2)) u_unlock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .acc_i     (bus_req_i),
    .we_i      (bus_we_i),
    .hit_unl_i (hit_unl),
    .wdata_i   (bus_wdata_i),
    .armed_o   (unl_armed)
  );

  pcg_ctrl_reg u_reg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (reg_wr),
    .wdata_i     (bus_wdata_i),
    .init_done_i (init_done_i),
    .armed_i     (unl_armed),
    .ctrl_q_o    (ctrl_q),
    .ctrl_d_o    (ctrl_d),
    .lock_o      (lock_q)
  );

  for (genvar i = 0; i < N_PERIPH; i++) begin : g_map
    assign dis_q[i] = ctrl_q[PERIPH_BIT[i]];
    assign dis_d[i] = ctrl_d[PERIPH_BIT[i]];
  end

  assign dis_clr = dis_q & ~dis_d;

  pcg_rst_pulser #(.N(N_PERIPH), .MASK(RST_MASK), .RST_CYCLES(RST_CYCLES)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (dis_clr),
    .rst_o  (periph_rst_o)
  );

  pcg_gate_out u_gate (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .dis_d_i      (dis_d),
    .pcd_d_i      (ctrl_d[PCD_BIT]),
    .dis_q_i      (dis_q),
    .pcd_q_i      (ctrl_q[PCD_BIT]),
    .clkout_src_i (clkout_src_i),
    .clk_en_o     (clk_en_o),
    .pclk_en_o    (pclk_en_o),
    .freeze_o     (port_freeze_o),
    .clkout_o     (clkout_o),
    .acc_ok_o     (reg_acc_ok_o)
  );

  assign bus_rdata_o = (bus_req_i & ~bus_we_i & hit_reg) ? ctrl_q : '0;
  assign irq_o       = irq_i;
endmodule

// File: rtl/pcg_checker.sv
module pcg_checker
  import pcg_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = 4'h0
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                bus_req_i,
  input logic                bus_we_i,
  input logic [ADDR_W-1:0]   bus_addr_i,
  input logic [N_PERIPH-1:0] clk_en_o,
  input logic [N_PERIPH-1:0] periph_rst_o,
  input logic [N_PERIPH-1:0] reg_acc_ok_o,
  input logic                port_freeze_o,
  input logic                clkout_o,
  input logic [REG_W-1:0]    ctrl_q,
  input logic                lock_q,
  input logic                unl_armed
);
  AST_CLKEN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(bus_req_i && bus_we_i && bus_addr_i == REG_ADDR) |-> $stable(clk_en_o)); // R3

  AST_RST_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(periph_rst_o[CAN_IDX]) |-> ($past(ctrl_q[PERIPH_BIT[CAN_IDX]]) && !ctrl_q[PERIPH_BIT[CAN_IDX]])); // R4

  AST_RST_MIN_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(periph_rst_o[CAN_IDX]) |=> periph_rst_o[CAN_IDX]); // R4

  AST_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(lock_q && !unl_armed) |-> $stable(ctrl_q)); // R5

  AST_CLKOUT_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_freeze_o |-> clkout_o); // R7

  AST_EXT_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_freeze_o |-> !reg_acc_ok_o[CAN_IDX]); // R9
endmodule

bind periph_clk_gate pcg_checker #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .bus_req_i     (bus_req_i),
  .bus_we_i      (bus_we_i),
  .bus_addr_i    (bus_addr_i),
  .clk_en_o      (clk_en_o),
  .periph_rst_o  (periph_rst_o),
  .reg_acc_ok_o  (reg_acc_ok_o),
  .port_freeze_o (port_freeze_o),
  .clkout_o      (clkout_o),
  .ctrl_q        (ctrl_q),
  .lock_q        (lock_q),
  .unl_armed     (unl_armed)
);

// File: tb/periph_clk_gate_tb.sv
module periph_clk_gate_tb_top;
  import pcg_pkg::*;

  localparam logic [3:0]  A_REG = 4'h0;
  localparam logic [3:0]  A_UNL = 4'h1;
  localparam logic [15:0] MASK  = 16'hA18F;
  localparam int BITS [7] = '{0, 1, 2, 3, 7, 8, 13};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0, init_done = 1'b0, csrc = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [7:0]  irq = '0;
  logic [15:0] rdata;
  logic [6:0]  clk_en, prst, acc_ok;
  logic        pclk_en, freeze, clkout;
  logic [7:0]  irq_out;

  int n_cmp = 0, n_bad = 0, cyc = 0;

  always #4 clk = ~clk;

  periph_clk_gate dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .init_done_i(init_done), .clkout_src_i(csrc), .irq_i(irq),
    .clk_en_o(clk_en), .pclk_en_o(pclk_en), .periph_rst_o(prst),
    .reg_acc_ok_o(acc_ok), .port_freeze_o(freeze), .clkout_o(clkout),
    .irq_o(irq_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0; init_done = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(posedge clk); #1;
    req = 1'b0;
  endtask

  task automatic idle();
    @(posedge clk); #1;
  endtask

  task automatic unlock();
    wr(A_UNL, 16'h00AA);
    wr(A_UNL, 16'h0055);
  endtask

  function automatic logic [6:0] exp_en(input logic [15:0] v);
    logic [6:0] e;
    for (int i = 0; i < 7; i++) e[i] = ~v[BITS[i]] & ~v[15];
    return e;
  endfunction

  function automatic logic [6:0] exp_acc(input logic [15:0] v);
    logic [6:0] e;
    for (int i = 0; i < 6; i++) e[i] = ~v[15] | v[BITS[i]];
    e[6] = ~v[15] & ~v[13];
    return e;
  endfunction

  task automatic chk_state(input logic [15:0] v);
    chk("R3", clk_en, exp_en(v));
    chk("R7", {pclk_en, clkout}, {~v[15], v[15] | csrc});
    chk("R8", freeze, v[15]);
    chk("R9", acc_ok, exp_acc(v));
    chk("R10", irq_out, irq);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 195000) begin
      n_bad++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] r, prev;
    int cnt;
    #13 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    rd(A_REG, r);
    chk("R1", r, 16'h0000);
    chk("R1", {clk_en, acc_ok, pclk_en, freeze, prst}, {7'h7F, 7'h7F, 1'b1, 1'b0, 7'h00});

    // R2 other address reads as zero
    rd(A_UNL, r);
    chk("R2", r, 16'h0000);

    // full sweep, unlocked
    prev = 16'h0000;
    cnt = 0;
    for (int v = 0; v < 65536; v++) begin
      logic [15:0] vv, m;
      vv = 16'(v);
      m = vv & MASK;
      csrc = ~csrc;
      irq = vv[7:0] ^ 8'h5A;
      chk("R3", clk_en, exp_en(prev)); // before edge: old value
      wr(A_REG, vv);
      cnt = (prev[13] & ~m[13]) ? 2 : (cnt > 0 ? cnt - 1 : 0);
      chk_state(m);
      chk("R4", prst, {(cnt != 0), 6'b0});
      if (v[1:0] == 2'b00) begin
        rd(A_REG, r);
        chk("R2", r, m);
        cnt = (cnt > 0) ? cnt - 1 : 0;
      end
      prev = m;
    end
    wr(A_REG, 16'h0000);
    idle(); idle(); idle();

    // R5 lock arrives with a write in the same cycle
    init_done = 1'b1;
    wr(A_REG, 16'h0001);
    rd(A_REG, r); chk("R5", r, 16'h0001);
    wr(A_REG, 16'h0002);
    rd(A_REG, r); chk("R5", r, 16'h0001);
    chk("R5", clk_en, exp_en(16'h0001));

    // R6 unlock opens one write
    unlock();
    wr(A_REG, 16'h0004);
    rd(A_REG, r); chk("R6", r, 16'h0004);
    wr(A_REG, 16'h0008);
    rd(A_REG, r); chk("R6", r, 16'h0004);

    // R6 read between unlock and write aborts
    unlock();
    rd(A_REG, r); chk("R6", r, 16'h0004);
    wr(A_REG, 16'h0080);
    rd(A_REG, r); chk("R6", r, 16'h0004);

    // R6 idle cycles do not abort
    wr(A_UNL, 16'h00AA);
    idle();
    wr(A_UNL, 16'h0055);
    idle();
    wr(A_REG, 16'h0080);
    rd(A_REG, r); chk("R6", r, 16'h0080);

    // R6 repeated first key restarts
    wr(A_UNL, 16'h00AA);
    wr(A_UNL, 16'h00AA);
    wr(A_UNL, 16'h0055);
    wr(A_REG, 16'h0100);
    rd(A_REG, r); chk("R6", r, 16'h0100);

    // R6 wrong order stays locked
    wr(A_UNL, 16'h0055);
    wr(A_UNL, 16'h00AA);
    wr(A_REG, 16'h0002);
    rd(A_REG, r); chk("R6", r, 16'h0100);

    // R4 re-enable pulse width
    unlock(); wr(A_REG, 16'h2000);
    idle(); idle(); idle();
    chk("R4", prst, 7'h00);
    unlock(); wr(A_REG, 16'h0000);
    chk("R4", prst, 7'h40);
    idle(); chk("R4", prst, 7'h40);
    idle(); chk("R4", prst, 7'h00);
    chk("R4", clk_en, 7'h7F);

    // same cycle: CAN re-enable and driver disable
    unlock(); wr(A_REG, 16'h2000);
    idle(); idle(); idle();
    unlock();
    csrc = 1'b0;
    wr(A_REG, 16'h8000);
    chk("R4", prst, 7'h40);
    chk_state(16'h8000);
    chk("R7", clkout, 1'b1);
    idle(); chk("R4", prst, 7'h40);
    idle(); chk("R4", prst, 7'h00);
    irq = 8'hC3; #1 chk("R10", irq_out, 8'hC3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule